// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer driven from a slow reference tick. Software programs it through a small 32-bit register bus. Every change of state needs a key value in the same write, so a stray store cannot alter the timer. A prescaler groups reference ticks into count units. A down-counter loaded from the programmed length then counts those units. When it runs out, the block raises an interrupt, issues a reset pulse, or does one and then the other, depending on the mode bits.

Software restarts the counter with a keyed write to keep the system alive. A separate keyed write forces an immediate reset pulse. The reference tick is a one-cycle strobe, synchronous to the bus clock. The reset output is a pulse whose length is counted in reference ticks.

Top module: `kwdog_top`

## Requirements
- R1: After reset the mode word reads 0, the length register reads its all-ones default shifted to bit 5, and both wd_rst and wd_irq are low.
- R2: A write to offset 0x00 changes the mode only when bits [31:24] equal 0x22. Writes with any other key are ignored. The mode bits are enable (bit 0), external reset enable (bit 2), interrupt select (bit 3) and dual mode (bit 6). A read returns only those bits, with the key field as zero.
- R3: A write to offset 0x04 changes the length only when bits [4:0] equal 0x08. The new length is taken from bits [LEN_W+4:5]. A read returns the length at bit 5 with the low five bits zero.
- R4: Writing exactly 0x1971 to offset 0x08 reloads the counter from the length, clears the prescaler, clears the interrupt and clears the dual-mode stage. Any other value has no effect.
- R5: While enabled, a timeout of length L (L ≥ 1) expires on the L×PRESC-th reference tick after a restart, and not before.
- R6: While the enable bit is clear, the prescaler and the counter hold their values, and counting resumes from the same point when the block is re-enabled.
- R7: With interrupt select set and dual mode clear, expiry sets wd_irq without any reset pulse. wd_irq then stays high until a restart.
- R8: With interrupt select and dual mode clear, expiry starts a reset pulse only if external reset enable is set. The pulse is high from the expiry edge for RST_TICKS further reference ticks.
- R9: In dual mode the first expiry sets wd_irq and reloads the counter. A second expiry with no restart in between starts the reset pulse when external reset enable is set. A restart between the two makes the next expiry an interrupt again.
- R10: Writing exactly 0x1209 to offset 0x14 starts the reset pulse at that write's clock edge, whatever the mode. Any other value there does nothing.
- R11: A restart issued while disabled loads the full length, so a later enable times out a full L×PRESC ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data including key field |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wd_rst | output | 1 | Reset pulse output |
| wd_irq | output | 1 | Sticky timeout interrupt |

## Verification
The hardest states to reach are the second expiry in dual mode and a countdown frozen partway through a count unit. Both depend on the exact number of reference ticks, which is normally hundreds of thousands of clocks. The bench shrinks the prescaler to four and drives each reference tick itself, so every expiry lands on a tick it can name. The bench steps the design to one tick before each boundary and then one tick past it. It disables the block partway through a unit and later resumes it.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_MODE    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_LEN     = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_RESTART = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SWRST   = 8'h14;

    localparam logic [7:0]        MODE_KEY    = 8'h22;
    localparam logic [4:0]        LEN_KEY     = 5'h08;
    localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_1971;
    localparam logic [DATA_W-1:0] SWRST_KEY   = 32'h0000_1209;

    localparam int LEN_LSB = 5;

    typedef struct packed {
        logic dual;
        logic irq_sel;
        logic ext_en;
        logic en;
    } mode_t;

    typedef struct packed {
        logic restart;
        logic swrst;
    } cmd_t;

    function automatic mode_t mode_decode(logic [DATA_W-1:0] w);
        mode_t m;
        m.en      = w[0];
        m.ext_en  = w[2];
        m.irq_sel = w[3];
        m.dual    = w[6];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] mode_encode(mode_t m);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = m.en;
        w[2] = m.ext_en;
        w[3] = m.irq_sel;
        w[6] = m.dual;
        return w;
    endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int LEN_RST = (1 << LEN_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output mode_t             mode_o,
    output logic [LEN_W-1:0]  len_o,
    output cmd_t              cmd_o
);

    localparam int LEN_MSB = LEN_LSB + LEN_W - 1;

    mode_t            mode_q;
    logic [LEN_W-1:0] len_q;
    logic             mode_we;
    logic             len_we;

    always_comb begin
        mode_we       = bus_wr && (bus_addr == OFF_MODE) && (bus_wdata[31:24] == MODE_KEY);
        len_we        = bus_wr && (bus_addr == OFF_LEN) && (bus_wdata[LEN_LSB-1:0] == LEN_KEY);
        cmd_o.restart = bus_wr && (bus_addr == OFF_RESTART) && (bus_wdata == RESTART_KEY);
        cmd_o.swrst   = bus_wr && (bus_addr == OFF_SWRST) && (bus_wdata == SWRST_KEY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            len_q  <= LEN_W'(LEN_RST);
        end else begin
            if (mode_we) mode_q <= mode_decode(bus_wdata);
            if (len_we)  len_q  <= bus_wdata[LEN_MSB:LEN_LSB];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_MODE: bus_rdata = mode_encode(mode_q);
            OFF_LEN:  bus_rdata[LEN_MSB:LEN_LSB] = len_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign mode_o = mode_q;
    assign len_o  = len_q;

endmodule

// File: rtl/kwd_count.sv
module kwd_count
    import kwd_pkg::*;
#(
    parameter int PRESC   = 512,
    parameter int LEN_W   = 11,
    parameter int LEN_RST = (1 << LEN_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  mode_t            mode,
    input  logic [LEN_W-1:0] len,
    input  logic             restart,
    output logic [LEN_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             expire_rst_o
);

    localparam int PRE_W = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESC - 1);

    logic [PRE_W-1:0] pre_q;
    logic [LEN_W-1:0] cnt_q;
    logic             stage_q;
    logic             irq_q;
    logic             step;
    logic             unit_done;
    logic             expire;
    logic             to_irq;

    always_comb begin
        step         = mode.en && ref_tick && !restart;
        unit_done    = step && (pre_q == PRE_LAST);
        expire       = unit_done && (cnt_q <= LEN_W'(1));
        to_irq       = expire && (mode.dual ? !stage_q : mode.irq_sel);
        expire_rst_o = expire && (mode.dual ? stage_q : !mode.irq_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            cnt_q   <= LEN_W'(LEN_RST);
            stage_q <= 1'b0;
            irq_q   <= 1'b0;
        end else if (restart) begin
            pre_q   <= '0;
            cnt_q   <= len;
            stage_q <= 1'b0;
            irq_q   <= 1'b0;
        end else if (step) begin
            if (unit_done) begin
                pre_q <= '0;
                cnt_q <= expire ? len : cnt_q - LEN_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
            if (expire) stage_q <= mode.dual && !stage_q;
            if (to_irq) irq_q   <= 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/kwd_rstgen.sv
module kwd_rstgen #(
    parameter int RST_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic start,
    output logic pulse_o
);

    localparam int RC_W = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_TICKS - 1);

    logic            active_q;
    logic [RC_W-1:0] rc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            rc_q     <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                rc_q     <= '0;
            end
        end else if (ref_tick) begin
            if (rc_q == RC_LAST) active_q <= 1'b0;
            else                 rc_q     <= rc_q + RC_W'(1);
        end
    end

    assign pulse_o = active_q;

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
    import kwd_pkg::*;
#(
    parameter int PRESC     = 512,
    parameter int LEN_W     = 11,
    parameter int LEN_RST   = (1 << LEN_W) - 1,
    parameter int RST_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_rst,
    output logic              wd_irq
);

    mode_t            mode_q;
    logic [LEN_W-1:0] len_w;
    cmd_t             cmd_w;
    logic [LEN_W-1:0] cnt_w;
    logic             exp_rst_w;
    logic             rst_start;

    kwd_regs #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .mode_o   (mode_q),
        .len_o    (len_w),
        .cmd_o    (cmd_w)
    );

    kwd_count #(.PRESC(PRESC), .LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_count (
        .clk         (clk),
        .rst         (rst),
        .ref_tick    (ref_tick),
        .mode        (mode_q),
        .len         (len_w),
        .restart     (cmd_w.restart),
        .cnt_o       (cnt_w),
        .irq_o       (wd_irq),
        .expire_rst_o(exp_rst_w)
    );

    assign rst_start = cmd_w.swrst || (exp_rst_w && mode_q.ext_en);

    kwd_rstgen #(.RST_TICKS(RST_TICKS)) u_rstgen (
        .clk     (clk),
        .rst     (rst),
        .ref_tick(ref_tick),
        .start   (rst_start),
        .pulse_o (wd_rst)
    );

endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
    import kwd_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              wd_rst,
    input logic              wd_irq,
    input mode_t             mode_q,
    input logic [LEN_W-1:0]  cnt
);

    logic rs_wr;
    logic sw_wr;
    assign rs_wr = bus_wr && (bus_addr == OFF_RESTART) && (bus_wdata == RESTART_KEY);
    assign sw_wr = bus_wr && (bus_addr == OFF_SWRST) && (bus_wdata == SWRST_KEY);

    AST_MODE_KEY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_MODE && bus_wdata[31:24] != MODE_KEY) |=> $stable(mode_q)); // R2
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rs_wr |=> !wd_irq); // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.en && !rs_wr) |=> $stable(cnt)); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wd_irq && !rs_wr) |=> wd_irq); // R7
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wd_rst && !ref_tick) |=> wd_rst); // R8
    AST_SWRST_NOW: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> wd_rst); // R10

endmodule

bind kwdog_top kwd_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .wd_rst   (wd_rst),
    .wd_irq   (wd_irq),
    .mode_q   (mode_q),
    .cnt      (cnt_w)
);

// File: tb/tb_kwdog_top.sv
module tb_kwdog_top;
    import kwd_pkg::*;

    localparam int PR  = 4;
    localparam int LW  = 11;
    localparam int RT  = 3;
    localparam logic [31:0] M_EN = 32'h01, M_EXT = 32'h04, M_IRQ = 32'h08, M_DUAL = 32'h40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_tick = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              wd_rst, wd_irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    kwdog_top #(.PRESC(PR), .LEN_W(LW), .RST_TICKS(RT)) dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_rst(wd_rst), .wd_irq(wd_irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic set_mode(logic [31:0] b); wr(OFF_MODE, 32'h2200_0000 | b); endtask
    task automatic set_len(int l);           wr(OFF_LEN, (32'(l) << 5) | 32'h8); endtask
    task automatic restart();                wr(OFF_RESTART, RESTART_KEY); endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(OFF_MODE, d); check("R1 mode", d, 32'h0);
        rd(OFF_LEN, d);  check("R1 len", d, 32'h0000_FFE0);
        check("R1 rst", {31'b0, wd_rst}, 32'h0);
        check("R1 irq", {31'b0, wd_irq}, 32'h0);

        // R2 key sweep on mode
        for (int k = 0; k < 256; k++) begin
            if (k != 8'h22) begin
                wr(OFF_MODE, {8'(k), 24'hFF_FFFF});
                rd(OFF_MODE, d); check("R2 bad key", d, 32'h0);
            end
        end
        wr(OFF_MODE, 32'h22FF_FFFF);
        rd(OFF_MODE, d); check("R2 good key", d, 32'h0000_004D);
        set_mode(32'h0);
        rd(OFF_MODE, d); check("R2 clear", d, 32'h0);

        // R3 key sweep on length
        for (int k = 0; k < 32; k++) begin
            if (k != 8) begin
                wr(OFF_LEN, (32'd5 << 5) | 32'(k));
                rd(OFF_LEN, d); check("R3 bad key", d, 32'h0000_FFE0);
            end
        end
        set_len(5);
        rd(OFF_LEN, d); check("R3 good key", d, 32'h0000_00A0);

        // R5 / R7 expiry timing sweep in interrupt mode
        for (int l = 1; l <= 6; l++) begin
            set_len(l); restart(); set_mode(M_EN | M_IRQ);
            tick(PR * l - 1);
            check("R5 before expiry", {31'b0, wd_irq}, 32'h0);
            tick(1);
            check("R5 at expiry", {31'b0, wd_irq}, 32'h1);
            check("R7 no reset", {31'b0, wd_rst}, 32'h0);
            tick(5);
            check("R7 sticky", {31'b0, wd_irq}, 32'h1);
            set_mode(32'h0); restart();
            check("R4 restart clears irq", {31'b0, wd_irq}, 32'h0);
        end

        // R4 wrong restart value ignored
        set_len(2); restart(); set_mode(M_EN | M_IRQ);
        tick(7);
        wr(OFF_RESTART, 32'h0000_1970);
        tick(1);
        check("R4 bad restart ignored", {31'b0, wd_irq}, 32'h1);
        set_mode(32'h0); restart();

        // R8 reset pulse with external enable
        for (int l = 1; l <= 3; l++) begin
            set_len(l); restart(); set_mode(M_EN | M_EXT);
            tick(PR * l - 1);
            check("R8 before expiry", {31'b0, wd_rst}, 32'h0);
            tick(1);
            check("R8 pulse start", {31'b0, wd_rst}, 32'h1);
            check("R8 no irq", {31'b0, wd_irq}, 32'h0);
            tick(RT - 1);
            check("R8 pulse held", {31'b0, wd_rst}, 32'h1);
            tick(1);
            check("R8 pulse end", {31'b0, wd_rst}, 32'h0);
            set_mode(32'h0); restart();
        end
        set_len(1); restart(); set_mode(M_EN);
        tick(PR);
        check("R8 no ext enable", {31'b0, wd_rst}, 32'h0);
        check("R8 no ext irq", {31'b0, wd_irq}, 32'h0);
        set_mode(32'h0); restart();

        // R6 freeze
        set_len(3); restart(); set_mode(M_EN | M_IRQ);
        tick(5);
        set_mode(M_IRQ);
        tick(20);
        check("R6 frozen", {31'b0, wd_irq}, 32'h0);
        set_mode(M_EN | M_IRQ);
        tick(6);
        check("R6 resume early", {31'b0, wd_irq}, 32'h0);
        tick(1);
        check("R6 resume expiry", {31'b0, wd_irq}, 32'h1);
        set_mode(32'h0); restart();

        // R11 restart while disabled gives a full timeout
        set_len(3); restart(); set_mode(M_EN | M_IRQ);
        tick(7);
        set_mode(32'h0); set_len(2); restart(); set_mode(M_EN | M_IRQ);
        tick(7);
        check("R11 full window", {31'b0, wd_irq}, 32'h0);
        tick(1);
        check("R11 expiry", {31'b0, wd_irq}, 32'h1);
        set_mode(32'h0); restart();

        // R9 dual mode
        set_len(2); restart(); set_mode(M_EN | M_EXT | M_DUAL);
        tick(8);
        check("R9 first irq", {31'b0, wd_irq}, 32'h1);
        check("R9 first no rst", {31'b0, wd_rst}, 32'h0);
        tick(7);
        check("R9 before second", {31'b0, wd_rst}, 32'h0);
        tick(1);
        check("R9 second rst", {31'b0, wd_rst}, 32'h1);
        tick(RT);
        check("R9 pulse done", {31'b0, wd_rst}, 32'h0);
        restart();
        tick(8);
        check("R9 irq after restart", {31'b0, wd_irq}, 32'h1);
        restart();
        tick(8);
        check("R9 stage cleared irq", {31'b0, wd_irq}, 32'h1);
        check("R9 stage cleared rst", {31'b0, wd_rst}, 32'h0);
        set_mode(32'h0); restart();

        // R10 software reset
        wr(OFF_SWRST, 32'h0000_1208);
        check("R10 bad value", {31'b0, wd_rst}, 32'h0);
        wr(OFF_SWRST, SWRST_KEY);
        check("R10 immediate", {31'b0, wd_rst}, 32'h1);
        tick(RT - 1);
        check("R10 held", {31'b0, wd_rst}, 32'h1);
        tick(1);
        check("R10 end", {31'b0, wd_rst}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule